// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block stands between one processor and an interrupt source unit. It keeps a single pending-interrupt slot together with the processor's current priority, and it drives one interrupt line toward the processor. Sources offer interrupts as a source number and a priority. The block either keeps an offer or hands it straight back with a reject pulse. When a more favoured offer arrives, it takes the slot and the source it displaced is rejected.

The processor works the block through four single-cycle strobes. It can write its current priority, write the inter-processor request priority, accept the pending interrupt (the acknowledge word is returned in the same cycle), and signal end-of-interrupt. When the slot becomes free, the block does not queue anything. It sends a resend request and the source unit offers its rejected interrupts again. Before that request goes out, the inter-processor request is checked again. Priorities are 8 bits wide, and a lower value is more favoured. The value 0xFF means masked or nothing pending.

The control core is a two-state machine. In `ST_EMPTY` no source is held. In `ST_HELD` a source number and its pending priority are latched and the interrupt line is high. It has four transitions:
- EMPTY to HELD, taken when an offer is kept or the inter-processor request is presented.
- HELD to HELD, taken when a more favoured offer or inter-processor request displaces the held source.
- HELD to EMPTY, taken on accept, or when a priority write masks the held source.
- EMPTY to EMPTY, taken on every other operation.

Top module: `icp_present`

## Requirements
- R1: After reset the acknowledge word is 0 (current priority 0x00, source field 0), the interrupt line is low, and the pending and inter-processor priorities are both 0xFF. An inter-processor write of 0xFF then has no visible effect.
- R2: An offer whose priority is equal to or numerically above the current priority (bits 31:24 of the acknowledge word) is rejected. In the next cycle rej_valid pulses with rej_src equal to the offered source, and the slot is unchanged.
- R3: An offer is rejected in the same way when a source is held whose pending priority is equal to or more favoured than the offer's priority.
- R4: Any other offer is latched. In the next cycle the acknowledge word's bits 23:0 hold its source and the interrupt line is high. If a source was already held, it is rejected in that same cycle.
- R5: Accept returns {current priority, held source} on ack_word in the cycle of the ack_rd strobe. In the next cycle the interrupt line is low, the source field is 0, and the current priority equals the pending priority that was held (0xFF if none was held).
- R6: A current-priority write that is more favoured than the old value, while a source is held whose pending priority is not strictly more favoured than the new value, clears the slot, lowers the line and rejects that source.
- R7: A current-priority write that is equal to or less favoured than the old value, with the slot empty, pulses resend_req.
- R8: An inter-processor write stores the value. If the value is more favoured than the current priority, source number IPI_SRC (default 2) is presented at that priority, unless a held source already has an equal or more favoured priority. A source it displaces is rejected.
- R9: End-of-interrupt loads the current priority from eoi_word bits 31:24 and pulses eoi_valid with eoi_src equal to bits 23:0. If the slot is empty, it also pulses resend_req.
- R10: Every resend first checks the inter-processor request again. If its priority is more favoured than the new current priority and the slot is empty, IPI_SRC is presented in the same cycle as the resend pulse.
- R11: Processor operations are one per cycle, with the precedence accept, end-of-interrupt, current-priority write, inter-processor write. While any of them is strobed, offer_ready is low and an offer has no effect.
- R12: rej_valid, eoi_valid and resend_req are single-cycle pulses. They fall back to 0 in a cycle with no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | Source unit offers an interrupt |
| offer_src | input | SRC_W (24) | Offered source number, nonzero |
| offer_prio | input | PRIO_W (8) | Offered priority |
| offer_ready | output | 1 | Offer is evaluated this cycle |
| cur_prio_wr | input | 1 | Write current processor priority |
| cur_prio_data | input | PRIO_W (8) | New current priority |
| ipi_prio_wr | input | 1 | Write inter-processor request priority |
| ipi_prio_data | input | PRIO_W (8) | New inter-processor priority |
| ack_rd | input | 1 | Accept strobe |
| ack_word | output | PRIO_W+SRC_W (32) | {current priority, held source} |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_word | input | PRIO_W+SRC_W (32) | {priority to restore, finished source} |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to the source unit |
| rej_src | output | SRC_W (24) | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source unit |
| eoi_src | output | SRC_W (24) | Finished source number |
| resend_req | output | 1 | Resend request pulse to the source unit |

## Verification
Offers are tried against a fully masked processor priority, against equal priorities, and against strictly more favoured priorities. The equal cases separate the strict comparison from a non-strict one at both the processor-priority gate and the pending-priority gate. A displacing offer separates "reject the newcomer" from "reject the incumbent". Inter-processor writes are made both below and above the held priority, which shows whether the bypass check is applied. Priority writes in both directions, and end-of-interrupt with the slot empty, confirm that resend and the inter-processor recheck happen together.

// File: rtl/icp_pkg.sv
package icp_pkg;

    typedef enum logic {
        ST_EMPTY,
        ST_HELD
    } slot_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_OFFER,
        OP_PRIO,
        OP_IPI,
        OP_ACK,
        OP_EOI
    } op_e;

endpackage

// File: rtl/icp_opsel.sv
module icp_opsel
    import icp_pkg::*;
(
    input  logic offer_valid,
    input  logic cur_prio_wr,
    input  logic ipi_prio_wr,
    input  logic ack_rd,
    input  logic eoi_wr,
    output op_e  op,
    output logic offer_ready
);

    logic proc_busy;

    assign proc_busy   = ack_rd | eoi_wr | cur_prio_wr | ipi_prio_wr;
    assign offer_ready = ~proc_busy;

    // Fixed precedence: accept, end-of-interrupt, priority write, IPI write, offer
    always_comb begin
        if (ack_rd)            op = OP_ACK;
        else if (eoi_wr)       op = OP_EOI;
        else if (cur_prio_wr)  op = OP_PRIO;
        else if (ipi_prio_wr)  op = OP_IPI;
        else if (offer_valid)  op = OP_OFFER;
        else                   op = OP_NONE;
    end

endmodule

// File: rtl/icp_decide.sv
module icp_decide
    import icp_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  op_e                       op,
    input  slot_state_e               cur_state,
    input  logic [PRIO_W-1:0]         cur_cppr,
    input  logic [SRC_W-1:0]          cur_src,
    input  logic [PRIO_W-1:0]         cur_pprio,
    input  logic [PRIO_W-1:0]         cur_mfrr,
    input  logic [PRIO_W-1:0]         prio_data,
    input  logic [PRIO_W-1:0]         ipi_data,
    input  logic [PRIO_W+SRC_W-1:0]   eoi_word,
    input  logic [SRC_W-1:0]          offer_src,
    input  logic [PRIO_W-1:0]         offer_prio,
    output slot_state_e               nxt_state,
    output logic [PRIO_W-1:0]         nxt_cppr,
    output logic [SRC_W-1:0]          nxt_src,
    output logic [PRIO_W-1:0]         nxt_pprio,
    output logic [PRIO_W-1:0]         nxt_mfrr,
    output logic                      rej_v,
    output logic [SRC_W-1:0]          rej_s,
    output logic                      eoi_v,
    output logic [SRC_W-1:0]          eoi_s,
    output logic                      rsnd
);

    localparam int                ACK_W     = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_MASK = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

    logic              held;
    logic [PRIO_W-1:0] eoi_prio;

    assign held     = (cur_state == ST_HELD);
    assign eoi_prio = eoi_word[ACK_W-1 -: PRIO_W];

    always_comb begin
        nxt_state = cur_state;
        nxt_cppr  = cur_cppr;
        nxt_src   = cur_src;
        nxt_pprio = cur_pprio;
        nxt_mfrr  = cur_mfrr;
        rej_v     = 1'b0;
        rej_s     = '0;
        eoi_v     = 1'b0;
        eoi_s     = '0;
        rsnd      = 1'b0;

        unique case (op)
            OP_ACK: begin
                // HELD -> EMPTY (or EMPTY -> EMPTY)
                nxt_cppr  = held ? cur_pprio : PRIO_MASK;
                nxt_state = ST_EMPTY;
                nxt_src   = '0;
                nxt_pprio = PRIO_MASK;
            end
            OP_EOI: begin
                nxt_cppr = eoi_prio;
                eoi_v    = 1'b1;
                eoi_s    = eoi_word[SRC_W-1:0];
                if (!held) begin
                    rsnd = 1'b1;
                    if (cur_mfrr < eoi_prio) begin
                        nxt_state = ST_HELD;
                        nxt_src   = IPI_NUM;
                        nxt_pprio = cur_mfrr;
                    end
                end
            end
            OP_PRIO: begin
                nxt_cppr = prio_data;
                if (prio_data < cur_cppr) begin
                    if (held && (prio_data <= cur_pprio)) begin
                        nxt_state = ST_EMPTY;
                        nxt_src   = '0;
                        nxt_pprio = PRIO_MASK;
                        rej_v     = 1'b1;
                        rej_s     = cur_src;
                    end
                end else if (!held) begin
                    rsnd = 1'b1;
                    if (cur_mfrr < prio_data) begin
                        nxt_state = ST_HELD;
                        nxt_src   = IPI_NUM;
                        nxt_pprio = cur_mfrr;
                    end
                end
            end
            OP_IPI: begin
                nxt_mfrr = ipi_data;
                if ((ipi_data < cur_cppr) && !(held && (cur_pprio <= ipi_data))) begin
                    if (held) begin
                        rej_v = 1'b1;
                        rej_s = cur_src;
                    end
                    nxt_state = ST_HELD;
                    nxt_src   = IPI_NUM;
                    nxt_pprio = ipi_data;
                end
            end
            OP_OFFER: begin
                if ((offer_prio >= cur_cppr) || (held && (cur_pprio <= offer_prio))) begin
                    rej_v = 1'b1;
                    rej_s = offer_src;
                end else begin
                    if (held) begin
                        rej_v = 1'b1;
                        rej_s = cur_src;
                    end
                    nxt_state = ST_HELD;
                    nxt_src   = offer_src;
                    nxt_pprio = offer_prio;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/icp_present.sv
module icp_present
    import icp_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      offer_valid,
    input  logic [SRC_W-1:0]          offer_src,
    input  logic [PRIO_W-1:0]         offer_prio,
    output logic                      offer_ready,
    input  logic                      cur_prio_wr,
    input  logic [PRIO_W-1:0]         cur_prio_data,
    input  logic                      ipi_prio_wr,
    input  logic [PRIO_W-1:0]         ipi_prio_data,
    input  logic                      ack_rd,
    output logic [PRIO_W+SRC_W-1:0]   ack_word,
    input  logic                      eoi_wr,
    input  logic [PRIO_W+SRC_W-1:0]   eoi_word,
    output logic                      irq_out,
    output logic                      rej_valid,
    output logic [SRC_W-1:0]          rej_src,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src,
    output logic                      resend_req
);

    localparam logic [PRIO_W-1:0] PRIO_MASK = '1;

    op_e               op;
    slot_state_e       state, nxt_state;
    logic [PRIO_W-1:0] cppr, nxt_cppr;
    logic [SRC_W-1:0]  src, nxt_src;
    logic [PRIO_W-1:0] pprio, nxt_pprio;
    logic [PRIO_W-1:0] mfrr, nxt_mfrr;
    logic              rej_v, eoi_v, rsnd;
    logic [SRC_W-1:0]  rej_s, eoi_s;

    icp_opsel u_opsel (
        .offer_valid (offer_valid),
        .cur_prio_wr (cur_prio_wr),
        .ipi_prio_wr (ipi_prio_wr),
        .ack_rd      (ack_rd),
        .eoi_wr      (eoi_wr),
        .op          (op),
        .offer_ready (offer_ready)
    );

    icp_decide #(
        .SRC_W   (SRC_W),
        .PRIO_W  (PRIO_W),
        .IPI_SRC (IPI_SRC)
    ) u_decide (
        .op         (op),
        .cur_state  (state),
        .cur_cppr   (cppr),
        .cur_src    (src),
        .cur_pprio  (pprio),
        .cur_mfrr   (mfrr),
        .prio_data  (cur_prio_data),
        .ipi_data   (ipi_prio_data),
        .eoi_word   (eoi_word),
        .offer_src  (offer_src),
        .offer_prio (offer_prio),
        .nxt_state  (nxt_state),
        .nxt_cppr   (nxt_cppr),
        .nxt_src    (nxt_src),
        .nxt_pprio  (nxt_pprio),
        .nxt_mfrr   (nxt_mfrr),
        .rej_v      (rej_v),
        .rej_s      (rej_s),
        .eoi_v      (eoi_v),
        .eoi_s      (eoi_s),
        .rsnd       (rsnd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            cppr  <= '0;
            src   <= '0;
            pprio <= PRIO_MASK;
            mfrr  <= PRIO_MASK;
        end else begin
            state <= nxt_state;
            cppr  <= nxt_cppr;
            src   <= nxt_src;
            pprio <= nxt_pprio;
            mfrr  <= nxt_mfrr;
        end
    end

    // Outputs toward processor and source unit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out    <= 1'b0;
            rej_valid  <= 1'b0;
            rej_src    <= '0;
            eoi_valid  <= 1'b0;
            eoi_src    <= '0;
            resend_req <= 1'b0;
        end else begin
            irq_out    <= (nxt_state == ST_HELD);
            rej_valid  <= rej_v;
            rej_src    <= rej_s;
            eoi_valid  <= eoi_v;
            eoi_src    <= eoi_s;
            resend_req <= rsnd;
        end
    end

    assign ack_word = {cppr, (state == ST_HELD) ? src : {SRC_W{1'b0}}};

endmodule

// File: rtl/icp_present_chk.sv
module icp_present_chk #(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    offer_valid,
    input logic [SRC_W-1:0]        offer_src,
    input logic [PRIO_W-1:0]       offer_prio,
    input logic                    offer_ready,
    input logic                    ack_rd,
    input logic [PRIO_W+SRC_W-1:0] ack_word,
    input logic                    eoi_wr,
    input logic [PRIO_W+SRC_W-1:0] eoi_word,
    input logic                    irq_out,
    input logic                    rej_valid,
    input logic [SRC_W-1:0]        rej_src,
    input logic                    eoi_valid,
    input logic [SRC_W-1:0]        eoi_src
);

    localparam int ACK_W = PRIO_W + SRC_W;

    a_r1_line_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (ack_word[SRC_W-1:0] != '0));

    a_r2_masked_offer_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && offer_ready && (offer_prio >= ack_word[ACK_W-1 -: PRIO_W]))
        |=> (rej_valid && (rej_src == $past(offer_src))));

    a_r4_offer_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && offer_ready && !irq_out && (offer_prio < ack_word[ACK_W-1 -: PRIO_W]))
        |=> (irq_out && (ack_word[SRC_W-1:0] == $past(offer_src)) && !rej_valid));

    a_r5_accept_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> (!irq_out && (ack_word[SRC_W-1:0] == '0)));

    a_r9_eoi_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !ack_rd) |=> (eoi_valid && (eoi_src == $past(eoi_word[SRC_W-1:0]))
                                 && (ack_word[ACK_W-1 -: PRIO_W] == $past(eoi_word[ACK_W-1 -: PRIO_W]))));

endmodule

bind icp_present icp_present_chk #(
    .SRC_W  (SRC_W),
    .PRIO_W (PRIO_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .offer_ready (offer_ready),
    .ack_rd      (ack_rd),
    .ack_word    (ack_word),
    .eoi_wr      (eoi_wr),
    .eoi_word    (eoi_word),
    .irq_out     (irq_out),
    .rej_valid   (rej_valid),
    .rej_src     (rej_src),
    .eoi_valid   (eoi_valid),
    .eoi_src     (eoi_src)
);

// File: tb/icp_present_test.sv
`timescale 1ns/1ps
module icp_present_test;

    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              offer_valid = 1'b0;
    logic [23:0]       offer_src = '0;
    logic [7:0]        offer_prio = '0;
    logic              offer_ready;
    logic              cur_prio_wr = 1'b0;
    logic [7:0]        cur_prio_data = '0;
    logic              ipi_prio_wr = 1'b0;
    logic [7:0]        ipi_prio_data = '0;
    logic              ack_rd = 1'b0;
    logic [31:0]       ack_word;
    logic              eoi_wr = 1'b0;
    logic [31:0]       eoi_word = '0;
    logic              irq_out, rej_valid, eoi_valid, resend_req;
    logic [23:0]       rej_src, eoi_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    icp_present #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
        .offer_ready(offer_ready),
        .cur_prio_wr(cur_prio_wr), .cur_prio_data(cur_prio_data),
        .ipi_prio_wr(ipi_prio_wr), .ipi_prio_data(ipi_prio_data),
        .ack_rd(ack_rd), .ack_word(ack_word),
        .eoi_wr(eoi_wr), .eoi_word(eoi_word),
        .irq_out(irq_out),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .resend_req(resend_req)
    );

    // op: 0 none, 1 offer (d[23:0]=src), 2 cur prio, 3 ipi prio, 4 accept, 5 eoi
    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] d;
        logic [7:0]  prio;
        logic        rv;
        logic [23:0] rs;
        logic        ev;
        logic [23:0] es;
        logic        rq;
        logic        irq;
        logic [31:0] ack;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{3'd1, 32'h10, 8'd5, 1'b1, 24'h10, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0000_0000}, // R2 masked
        '{3'd2, 32'hFF, 8'd0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b1, 1'b0, 32'hFF00_0000}, // R7 resend
        '{3'd1, 32'h10, 8'd5, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0, 1'b1, 32'hFF00_0010}, // R4 latch
        '{3'd1, 32'h20, 8'd5, 1'b1, 24'h20, 1'b0, 24'h0, 1'b0, 1'b1, 32'hFF00_0010}, // R3 equal
        '{3'd1, 32'h30, 8'd3, 1'b1, 24'h10, 1'b0, 24'h0, 1'b0, 1'b1, 32'hFF00_0030}, // R4 displace
        '{3'd4, 32'h0,  8'd0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0, 1'b0, 32'h0300_0000}, // R5 accept
        '{3'd1, 32'h40, 8'd3, 1'b1, 24'h40, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0300_0000}, // R2 equal
        '{3'd5, 32'hFF00_0030, 8'd0, 1'b0, 24'h0, 1'b1, 24'h30, 1'b1, 1'b0, 32'hFF00_0000}, // R9
        '{3'd3, 32'h06, 8'd0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0, 1'b1, 32'hFF00_0002}, // R8 present
        '{3'd1, 32'h50, 8'd4, 1'b1, 24'h2,  1'b0, 24'h0, 1'b0, 1'b1, 32'hFF00_0050}, // R4 over IPI
        '{3'd2, 32'h04, 8'd0, 1'b1, 24'h50, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0400_0000}, // R6 mask
        '{3'd2, 32'h08, 8'd0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b1, 1'b1, 32'h0800_0002}, // R10 recheck
        '{3'd3, 32'h07, 8'd0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0, 1'b1, 32'h0800_0002}, // R8 bypass
        '{3'd3, 32'h01, 8'd0, 1'b1, 24'h2,  1'b0, 24'h0, 1'b0, 1'b1, 32'h0800_0002}, // R8 displace
        '{3'd4, 32'h0,  8'd0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0, 1'b0, 32'h0100_0000}, // R5 accept
        '{3'd5, 32'h0800_0002, 8'd0, 1'b0, 24'h0, 1'b1, 24'h2, 1'b1, 1'b1, 32'h0800_0002} // R10 eoi
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        offer_valid = 1'b0; cur_prio_wr = 1'b0; ipi_prio_wr = 1'b0;
        ack_rd = 1'b0; eoi_wr = 1'b0;
    endtask

    task automatic drive(input logic [2:0] op, input logic [31:0] d, input logic [7:0] p);
        clear_inputs();
        case (op)
            3'd1: begin offer_valid = 1'b1; offer_src = d[23:0]; offer_prio = p; end
            3'd2: begin cur_prio_wr = 1'b1; cur_prio_data = d[7:0]; end
            3'd3: begin ipi_prio_wr = 1'b1; ipi_prio_data = d[7:0]; end
            3'd4: ack_rd = 1'b1;
            3'd5: begin eoi_wr = 1'b1; eoi_word = d; end
            default: ;
        endcase
    endtask

    // inputs applied at negedge, registered at posedge, sampled at the following negedge
    task automatic finish_cycle();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 ack_word", ack_word, 32'h0);
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(3'd3, 32'hFF, 8'd0);
        finish_cycle();
        check("R1 ipi 0xFF no effect ack", ack_word, 32'h0);
        check("R1 ipi 0xFF no effect irq", {31'b0, irq_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VT[i].op, VT[i].d, VT[i].prio);
            if (VT[i].op == 3'd4) begin
                #1;
                // R5 value returned in strobe cycle
                if (i == 5) check("R5 same-cycle word", ack_word, 32'hFF00_0030);
                else        check("R5 same-cycle word", ack_word, 32'h0800_0002);
            end
            finish_cycle();
            check($sformatf("step%0d rej_valid R2/R3/R4/R6/R8", i), {31'b0, rej_valid}, {31'b0, VT[i].rv});
            if (VT[i].rv) check($sformatf("step%0d rej_src R2/R3/R4/R6/R8", i), {8'b0, rej_src}, {8'b0, VT[i].rs});
            check($sformatf("step%0d eoi_valid R9", i), {31'b0, eoi_valid}, {31'b0, VT[i].ev});
            if (VT[i].ev) check($sformatf("step%0d eoi_src R9", i), {8'b0, eoi_src}, {8'b0, VT[i].es});
            check($sformatf("step%0d resend R7/R9/R10", i), {31'b0, resend_req}, {31'b0, VT[i].rq});
            check($sformatf("step%0d irq R4/R5/R6", i), {31'b0, irq_out}, {31'b0, VT[i].irq});
            check($sformatf("step%0d ack_word R4/R5/R8", i), ack_word, VT[i].ack);
        end

        // R12: pulses drop in an idle cycle
        drive(3'd1, 32'h70, 8'd9);   // rejected: 9 >= 8
        finish_cycle();
        check("R12 reject pulse", {31'b0, rej_valid}, 32'h1);
        finish_cycle();
        check("R12 reject falls", {31'b0, rej_valid}, 32'h0);
        check("R12 eoi quiet", {31'b0, eoi_valid}, 32'h0);
        check("R12 resend quiet", {31'b0, resend_req}, 32'h0);

        // R11: offer during a priority write is ignored
        drive(3'd2, 32'h08, 8'd0);
        offer_valid = 1'b1; offer_src = 24'h60; offer_prio = 8'd0;
        #1;
        check("R11 offer_ready low", {31'b0, offer_ready}, 32'h0);
        finish_cycle();
        check("R11 offer ignored rej", {31'b0, rej_valid}, 32'h0);
        check("R11 offer ignored word", ack_word, 32'h0800_0002);

        // R11: accept beats end-of-interrupt
        drive(3'd4, 32'h0, 8'd0);
        eoi_wr = 1'b1; eoi_word = 32'h0500_0077;
        finish_cycle();
        check("R11 accept wins eoi_valid", {31'b0, eoi_valid}, 32'h0);
        check("R11 accept wins word", ack_word, 32'h0100_0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule